// File: doc/BRIEF.md
# Single-word direct-mapped data cache with selectable write policies

This block is a direct-mapped data cache controller between a processor load/store port and a word-wide main-memory port. Each cache line holds one data word with a valid bit, a dirty bit and a tag. The line is chosen by the low address bits. The remaining upper bits are compared with the stored tag to decide hit or miss.

Two static parameters set the policies. The first chooses how a store hit is handled: write-through or write-back. The second chooses how a store miss is handled: write-allocate or write-around. A per-request non-temporal flag makes a single store miss skip allocation. In write-back mode, a miss that lands on a valid dirty line first writes the old word back to memory. The controller rebuilds that word's address from the stored tag and the index. Only after that write-back does it refill the line or install the new store.

The processor holds its request until a single-cycle `cpu_ready` marks completion. The memory port holds `mem_req` with a stable address, direction and write data until memory returns a one-cycle `mem_ack`. Read data arrives together with `mem_ack`.

Top module: `wpol_dcache`

## Requirements
- R1: After reset every line is invalid and clean, `cpu_ready` and `mem_req` are low, and the first access to any address is a miss.
- R2: With the default widths, the line index is `addr[2:0]` and the tag is `addr[7:3]`. Only addresses with equal index compete for a line, and an access to one index leaves every other line unchanged.
- R3: A load hit returns the line's word and causes no memory transaction.
- R4: A load miss onto a line that is not dirty performs one memory read at the load address. It installs the word as a valid, clean line and returns it.
- R5: In write-through mode, a store hit updates the line, leaves it clean, and performs exactly one memory write of the data at the store address.
- R6: In write-back mode, a store hit updates only the line, marks it dirty and causes no memory transaction. Later loads to that address return the new word.
- R7: In write-back mode, a load miss or an allocating store miss onto a valid dirty line first writes the old word to `{old tag, index}`. After that, a load performs its refill read and leaves the line clean. An allocating store installs its data dirty with no memory read.
- R8: Under write-allocate, a store miss installs the data with its tag and valid bit set. In write-back mode the line is dirty and there is no memory traffic. In write-through mode the line is clean and one memory write follows.
- R9: Under write-around, a store miss performs one memory write and leaves the line's contents untouched.
- R10: A store carrying the non-temporal flag that misses behaves as write-around even in write-allocate mode. On a hit, the flag has no effect and the hit policy applies.
- R11: `cpu_ready` is high for exactly one cycle per request. `mem_req` stays high with a stable address, direction and data until `mem_ack`.
- R12: Every load returns the most recently stored value of its address, for every policy combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_nt | input | 1 | Non-temporal hint for stores |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle memory completion |

## Verification
The bench runs four instances, one for each policy pair. All four get the same directed sequence and then seeded random traffic. The random addresses are confined to four indices and three tags, so that hits, clean conflicts, dirty evictions, non-temporal hits and misses all occur often.

For every request, the bench compares the exact ordered list of memory operations with the list its own line model predicts. This is what tells the four policies apart: no traffic on a write-back hit, a write on a write-through hit, write-then-read on a dirty load miss, and a lone write on write-around. Every load's data is also compared against the architectural value of its address, which exposes a stale or lost dirty word. Memory latency varies between requests, which tests that the request is held until acknowledged.

// File: rtl/wpol_dcache_pkg.sv
package wpol_dcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOKUP = 3'd1,
    ST_EVICT  = 3'd2,
    ST_FILL   = 3'd3,
    ST_MEMWR  = 3'd4,
    ST_DONE   = 3'd5
  } wpol_state_e;

endpackage

// File: rtl/wpol_line_store.sv
module wpol_line_store #(
  parameter int IDX_W      = 3,
  parameter int TAG_W      = 5,
  parameter int DATA_W     = 16,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty
);

  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_vec;
  logic [LINES-1:0]  dirty_vec;
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [DATA_W-1:0] data_arr [LINES];

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic              sel;
      logic              v_q;
      logic              d_q;
      logic [TAG_W-1:0]  t_q;
      logic [DATA_W-1:0] w_q;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      // status bits carry reset, payload does not
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= 1'b0;
        end else if (sel) begin
          v_q <= 1'b1;
          d_q <= wr_dirty;
        end
      end

      always_ff @(posedge clk) begin
        if (sel) begin
          t_q <= wr_tag;
          w_q <= wr_data;
        end
      end

      assign valid_vec[g] = v_q;
      assign dirty_vec[g] = d_q;
      assign tag_arr[g]   = t_q;
      assign data_arr[g]  = w_q;
    end
  endgenerate

  always_comb begin
    rd_valid = valid_vec[rd_idx];
    rd_dirty = dirty_vec[rd_idx];
    rd_tag   = tag_arr[rd_idx];
    rd_data  = data_arr[rd_idx];
  end

  // R5: a write-through configuration never leaves any line dirty
  p_wt_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_BACK) |-> (dirty_vec == '0));

endmodule

// File: rtl/wpol_ctrl.sv
module wpol_ctrl
  import wpol_dcache_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 3,
  parameter int DATA_W      = 16,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic                    cpu_nt,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_ready,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    mem_ack,
  output logic [IDX_W-1:0]        ln_idx,
  input  logic                    rd_valid,
  input  logic                    rd_dirty,
  input  logic [ADDR_W-IDX_W-1:0] rd_tag,
  input  logic [DATA_W-1:0]       rd_data,
  output logic                    ln_we,
  output logic [ADDR_W-IDX_W-1:0] ln_tag,
  output logic [DATA_W-1:0]       ln_data,
  output logic                    ln_dirty
);

  localparam int TAG_W = ADDR_W - IDX_W;

  wpol_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic              nt_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              cap_en;

  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic              hit;
  logic              victim_dirty;
  logic              alloc;

  assign idx_q        = addr_q[IDX_W-1:0];
  assign tag_q        = addr_q[ADDR_W-1:IDX_W];
  assign hit          = rd_valid && (rd_tag == tag_q);
  assign victim_dirty = WRITE_BACK && rd_valid && rd_dirty;
  assign alloc        = WRITE_ALLOC && !nt_q;
  assign cap_en       = (state_q == ST_IDLE) && cpu_req;

  assign ln_idx  = idx_q;
  assign ln_tag  = tag_q;

  // next-state and line-update decisions
  always_comb begin
    state_d  = state_q;
    ln_we    = 1'b0;
    ln_dirty = 1'b0;
    ln_data  = wdata_q;
    rdata_en = 1'b0;
    rdata_d  = rd_data;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (!we_q) begin
          if (hit) begin
            rdata_en = 1'b1;
            state_d  = ST_DONE;
          end else begin
            state_d = victim_dirty ? ST_EVICT : ST_FILL;
          end
        end else if (hit) begin
          ln_we    = 1'b1;
          ln_dirty = WRITE_BACK;
          state_d  = WRITE_BACK ? ST_DONE : ST_MEMWR;
        end else if (alloc) begin
          if (victim_dirty) begin
            state_d = ST_EVICT;
          end else begin
            ln_we    = 1'b1;
            ln_dirty = WRITE_BACK;
            state_d  = WRITE_BACK ? ST_DONE : ST_MEMWR;
          end
        end else begin
          state_d = ST_MEMWR;
        end
      end
      ST_EVICT: begin
        if (mem_ack) begin
          if (we_q) begin
            ln_we    = 1'b1;
            ln_dirty = 1'b1;
            state_d  = ST_DONE;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          ln_we    = 1'b1;
          ln_data  = mem_rdata;
          rdata_en = 1'b1;
          rdata_d  = mem_rdata;
          state_d  = ST_DONE;
        end
      end
      ST_MEMWR: begin
        if (mem_ack) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= cpu_addr;
      we_q    <= cpu_we;
      nt_q    <= cpu_nt;
      wdata_q <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rdata_en) rdata_q <= rdata_d;
  end

  // memory port is decoded from the state and the held request
  always_comb begin
    mem_req   = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_MEMWR);
    mem_we    = (state_q != ST_FILL);
    mem_addr  = (state_q == ST_EVICT) ? {rd_tag, idx_q} : addr_q;
    mem_wdata = (state_q == ST_EVICT) ? rd_data : wdata_q;
  end

  assign cpu_ready = (state_q == ST_DONE);
  assign cpu_rdata = rdata_q;

  // R11: an outstanding memory request is held unchanged until acknowledged
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata)));

  // R11: completion is a single-cycle pulse
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R7: a load's eviction is followed directly by the refill read of the load address
  p_fill_after_evict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT && mem_ack && !we_q) |=>
      (mem_req && !mem_we && mem_addr == $past(addr_q)));

  // R3: a load hit produces no memory request
  p_load_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOKUP && !we_q && hit) |=> !mem_req);

  // R6: a write-back store hit produces no memory request
  p_wb_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOKUP && we_q && hit && WRITE_BACK) |=> !mem_req);

endmodule

// File: rtl/wpol_dcache.sv
module wpol_dcache #(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 3,
  parameter int DATA_W      = 16,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_nt,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  ln_idx;
  logic              rd_valid;
  logic              rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              ln_we;
  logic [TAG_W-1:0]  ln_tag;
  logic [DATA_W-1:0] ln_data;
  logic              ln_dirty;

  wpol_ctrl #(
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W),
    .DATA_W      (DATA_W),
    .WRITE_BACK  (WRITE_BACK),
    .WRITE_ALLOC (WRITE_ALLOC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_nt    (cpu_nt),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .ln_idx    (ln_idx),
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_tag    (rd_tag),
    .rd_data   (rd_data),
    .ln_we     (ln_we),
    .ln_tag    (ln_tag),
    .ln_data   (ln_data),
    .ln_dirty  (ln_dirty)
  );

  wpol_line_store #(
    .IDX_W      (IDX_W),
    .TAG_W      (TAG_W),
    .DATA_W     (DATA_W),
    .WRITE_BACK (WRITE_BACK)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (ln_idx),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_tag   (rd_tag),
    .rd_data  (rd_data),
    .wr_en    (ln_we),
    .wr_idx   (ln_idx),
    .wr_tag   (ln_tag),
    .wr_data  (ln_data),
    .wr_dirty (ln_dirty)
  );

endmodule

// File: tb/wpol_dcache_tb_top.sv
`timescale 1ns/1ps

module wpol_dcache_env #(
  parameter bit WB   = 1'b1,
  parameter bit WA   = 1'b1,
  parameter int SEED = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_fail
);

  logic        cpu_req, cpu_we, cpu_nt, cpu_ready;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  wpol_dcache #(
    .ADDR_W(8), .IDX_W(3), .DATA_W(16), .WRITE_BACK(WB), .WRITE_ALLOC(WA)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_nt(cpu_nt), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [15:0] init_word(int a);
    return 16'(a * 257) ^ 16'h5a3c;
  endfunction

  // external memory with random latency, recording every completed operation
  logic [15:0] mem [256];
  int          lat;
  int          n_ops;
  logic        op_we   [4];
  logic [7:0]  op_addr [4];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = init_word(i);
      mem_ack = 1'b0;
      mem_rdata = '0;
      lat = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (lat == 0) begin
        mem_ack = 1'b1;
        mem_rdata = mem[mem_addr];
        if (mem_we) mem[mem_addr] = mem_wdata;
        if (n_ops < 4) begin
          op_we[n_ops]   = mem_we;
          op_addr[n_ops] = mem_addr;
        end
        n_ops++;
        lat = $urandom % 3;
      end else begin
        lat--;
      end
    end
  end

  // reference line model built from the requirements
  bit          mv [8];
  bit          md [8];
  logic [4:0]  mt [8];
  logic [15:0] arch [256];
  int          e_n;
  logic        e_we   [2];
  logic [7:0]  e_addr [2];
  string       e_tag;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (WB=%0d WA=%0d) %s: actual %0h expected %0h",
               req, WB, WA, what, act, exp);
    end
  endtask

  task automatic push(input logic w, input logic [7:0] a);
    e_we[e_n]   = w;
    e_addr[e_n] = a;
    e_n++;
  endtask

  task automatic predict(input logic we, input logic nt, input logic [7:0] a,
                         input logic [15:0] wd);
    int         i  = int'(a[2:0]);
    logic [4:0] t  = a[7:3];
    bit         h  = mv[i] && (mt[i] == t);
    bit         vd = WB && mv[i] && md[i];
    e_n = 0;
    if (!we) begin
      if (h) e_tag = "R3";
      else begin
        e_tag = vd ? "R7" : "R4";
        if (vd) push(1'b1, {mt[i], a[2:0]});
        push(1'b0, a);
        mv[i] = 1'b1; md[i] = 1'b0; mt[i] = t;
      end
    end else begin
      arch[a] = wd;
      if (h) begin
        if (WB) begin md[i] = 1'b1; e_tag = "R6"; end
        else begin push(1'b1, a); e_tag = "R5"; end
      end else if (WA && !nt) begin
        e_tag = vd ? "R7" : "R8";
        if (vd) push(1'b1, {mt[i], a[2:0]});
        mv[i] = 1'b1; md[i] = WB; mt[i] = t;
        if (!WB) push(1'b1, a);
      end else begin
        e_tag = (WA && nt) ? "R10" : "R9";
        push(1'b1, a);
      end
    end
  endtask

  task automatic do_req(input logic we, input logic nt, input logic [7:0] a,
                        input logic [15:0] wd, input string lbl);
    int          cyc = 0;
    bit          ok;
    logic [15:0] rd;
    string       tg;
    predict(we, nt, a, wd);
    tg = (lbl == "") ? e_tag : lbl;
    @(negedge clk);
    n_ops = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_nt = nt; cpu_addr = a; cpu_wdata = wd;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 100);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    ok = (n_ops == e_n) && cpu_ready;
    if (ok) for (int k = 0; k < e_n; k++)
      ok = ok && (op_we[k] == e_we[k]) && (op_addr[k] == e_addr[k]);
    check(ok, tg, "memory operations (count*512+we0*256+addr0)",
          32'(n_ops * 512 + (n_ops > 0 ? int'(op_we[0]) * 256 + int'(op_addr[0]) : 0)),
          32'(e_n * 512 + (e_n > 0 ? int'(e_we[0]) * 256 + int'(e_addr[0]) : 0)));
    if (!we) check(rd == arch[a], "R12", "load data", 32'(rd), 32'(arch[a]));
    @(negedge clk);
    check(!cpu_ready, "R11", "ready pulse length", 32'(cpu_ready), 32'(0));
  endtask

  initial begin
    done = 1'b0; n_chk = 0; n_fail = 0; n_ops = 0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_nt = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    void'($urandom(SEED));
    for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; md[i] = 1'b0; mt[i] = '0; end
    for (int i = 0; i < 256; i++) arch[i] = init_word(i);
    wait (rst_n === 1'b1);
    @(negedge clk);
    check(!cpu_ready && !mem_req, "R1", "idle outputs after reset",
          {30'd0, cpu_ready, mem_req}, 32'd0);
    // directed corner cases
    do_req(1'b0, 1'b0, 8'h05, 16'h0,    "R1");   // cold miss
    do_req(1'b0, 1'b0, 8'h05, 16'h0,    "");     // load hit
    do_req(1'b1, 1'b0, 8'h05, 16'h1111, "");     // store hit
    do_req(1'b0, 1'b0, 8'h05, 16'h0,    "");     // read back stored word
    do_req(1'b0, 1'b0, 8'h0D, 16'h0,    "");     // same index, other tag
    do_req(1'b0, 1'b0, 8'h05, 16'h0,    "");     // refilled line was clean
    do_req(1'b1, 1'b0, 8'h15, 16'h2222, "");     // store miss, clean victim
    do_req(1'b1, 1'b0, 8'h1D, 16'h3333, "");     // store miss, dirty victim
    do_req(1'b1, 1'b1, 8'h25, 16'h4444, "");     // non-temporal miss
    do_req(1'b0, 1'b0, 8'h1D, 16'h0,    "");     // line kept by bypass
    do_req(1'b0, 1'b0, 8'h0E, 16'h0,    "R2");   // other index
    do_req(1'b0, 1'b0, 8'h1D, 16'h0,    "R2");   // index 5 undisturbed
    do_req(1'b1, 1'b1, 8'h1D, 16'h5555, "R10");  // non-temporal hit uses hit policy
    do_req(1'b0, 1'b0, 8'h25, 16'h0,    "");
    // seeded random traffic on a few indices and tags
    for (int n = 0; n < 220; n++) begin
      logic       w  = 1'($urandom % 2);
      logic       nt = (($urandom % 4) == 0);
      logic [7:0] a  = {3'd0, 2'($urandom % 3), 1'b0, 2'($urandom % 4)};
      do_req(w, nt, a, 16'($urandom), "");
    end
    done = 1'b1;
  end

endmodule

module wpol_dcache_tb_top;

  logic clk;
  logic rst_n;
  logic d0, d1, d2, d3;
  int   c0, c1, c2, c3;
  int   f0, f1, f2, f3;
  bit   timeout;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    rst_n = 1'b0;
    timeout = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  end

  wpol_dcache_env #(.WB(1'b1), .WA(1'b1), .SEED(11)) u_env_wb_wa (
    .clk(clk), .rst_n(rst_n), .done(d0), .n_chk(c0), .n_fail(f0));
  wpol_dcache_env #(.WB(1'b1), .WA(1'b0), .SEED(23)) u_env_wb_wr (
    .clk(clk), .rst_n(rst_n), .done(d1), .n_chk(c1), .n_fail(f1));
  wpol_dcache_env #(.WB(1'b0), .WA(1'b1), .SEED(37)) u_env_wt_wa (
    .clk(clk), .rst_n(rst_n), .done(d2), .n_chk(c2), .n_fail(f2));
  wpol_dcache_env #(.WB(1'b0), .WA(1'b0), .SEED(41)) u_env_wt_wr (
    .clk(clk), .rst_n(rst_n), .done(d3), .n_chk(c3), .n_fail(f3));

  initial begin
    repeat (150000) @(posedge clk);
    timeout = 1'b1;
  end

  initial begin
    int total;
    int bad;
    wait ((d0 && d1 && d2 && d3) || timeout);
    total = c0 + c1 + c2 + c3;
    bad   = f0 + f1 + f2 + f3;
    if (timeout && !(d0 && d1 && d2 && d3)) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog: actual hung expected completion");
    end
    $display("  %0d/%0d checks passed", total - bad, total);
    $finish;
  end

endmodule